// File: doc/BRIEF.md
# PCI Configuration Write Sequencer

This block turns a host I/O write into a single-data-phase PCI configuration write. A programmable key register gates the configuration window. While the key is non-zero, a host I/O write into the window CnXXh (n from 1 to 15) is translated into a configuration write to PCI device n. The device number becomes a one-hot IDSEL line among AD[31:17], and the low address byte becomes the dword-aligned register offset.

The request is captured in the clock that accepts it. The block then drives one address phase and one data phase. The data phase carries the upper or lower dword of the 64-bit host data bus, with that dword's byte enables. The block holds IRDY# until the target answers with TRDY#. It then releases the AD drive enable and gives the host a ready pulse one clock wide. Accesses outside the window, accesses to n = 0 and accesses with a zero key do not start a PCI cycle.

Top module: `pci_cfg_wr_seq`

## Requirements
- R1: While the key input is zero, no host request starts a PCI cycle: FRAME# stays high and host ready stays low.
- R2: A request is decoded only when address bits [15:12] equal Ch and bits [11:8] (the device number n) are non-zero. Requests with n = 0 or with any other upper nibble are ignored.
- R3: In the address phase, AD[16+n] is the only bit set among AD[31:17]. AD[7:2] carries host address bits [7:2], AD[1:0] is 00, AD[16:8] is zero, and the AD drive enable is high.
- R4: The address phase falls in the clock after the request is sampled. In that phase C/BE#[3:0] = 1011 and FRAME# is low for exactly one clock.
- R5: Host address bit 2 = 1 selects data[63:32] with byte enables [7:4]. Bit 2 = 0 selects data[31:0] with byte enables [3:0]. The active-high enables of the chosen dword are driven inverted on C/BE# in the data phase.
- R6: In the data phase, IRDY# is low, FRAME# is high and AD carries the selected write data with the drive enable high. This holds for every clock in which TRDY# is sampled high.
- R7: In the clock after TRDY# is sampled low, IRDY# is high, the AD drive enable is low and host ready is high. Host ready lasts exactly one clock, after which the block is idle.
- R8: A request is accepted only while idle. A request presented during a cycle in progress is dropped and starts nothing afterwards.
- R9: After reset, FRAME# and IRDY# are high, C/BE# is 1111, AD is zero, the drive enable is low and host ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_key | input | KEY_W | Configuration window key; non-zero enables the window |
| host_req | input | 1 | Host I/O write strobe |
| host_addr | input | 14 | Host I/O dword address, bits [15:2] |
| host_be | input | 8 | Host byte enables, active high |
| host_data | input | 64 | Host write data |
| host_rdy | output | 1 | One-clock completion to the host |
| frame_n | output | 1 | PCI FRAME# |
| irdy_n | output | 1 | PCI IRDY# |
| trdy_n | input | 1 | PCI TRDY# from the target |
| cbe_n | output | 4 | PCI command / byte enables, active low |
| ad_out | output | 32 | PCI AD value to drive |
| ad_oe | output | 1 | AD drive enable |

## Verification
Assertions check several protocol rules on every cycle. FRAME# lasts one clock and is always paired with the configuration-write command and a single IDSEL bit. IRDY# holds while TRDY# is high. Host ready is a single-clock pulse that only follows a sampled TRDY#. A zero key never opens a cycle. Only the bench scenarios can show the exact IDSEL bit for each of the 15 device numbers, the offset and dword data values, the effect of 0 to 4 target wait states, and that requests outside the window or made while busy leave the bus quiet.

// File: rtl/pci_cfg_wr_seq.sv
module pci_cfg_wr_seq #(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] cfg_key,
  input  logic             host_req,
  input  logic [15:2]      host_addr,
  input  logic [7:0]       host_be,
  input  logic [63:0]      host_data,
  output logic             host_rdy,
  output logic             frame_n,
  output logic             irdy_n,
  input  logic             trdy_n,
  output logic [3:0]       cbe_n,
  output logic [31:0]      ad_out,
  output logic             ad_oe
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_DONE} st_t;

  st_t         st;
  logic [3:0]  dev_q;
  logic [7:2]  reg_q;
  logic [7:0]  be_q;
  logic [63:0] data_q;

  wire hit = host_req && (|cfg_key) && (host_addr[15:12] == 4'hC) && (|host_addr[11:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dev_q  <= '0;
      reg_q  <= '0;
      be_q   <= '0;
      data_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (hit) begin
          st     <= S_ADDR;
          dev_q  <= host_addr[11:8];
          reg_q  <= host_addr[7:2];
          be_q   <= host_be;
          data_q <= host_data;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: if (!trdy_n) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [14:0] idsel     = 15'd1 << (dev_q - 4'd1);
  wire [31:0] addr_word = {idsel, 9'd0, reg_q, 2'b00};
  wire [31:0] data_word = reg_q[2] ? data_q[63:32] : data_q[31:0];
  wire [3:0]  be_word   = reg_q[2] ? be_q[7:4] : be_q[3:0];

  assign frame_n  = (st != S_ADDR);
  assign irdy_n   = (st != S_DATA);
  assign host_rdy = (st == S_DONE);
  assign ad_oe    = (st == S_ADDR) || (st == S_DATA);
  assign ad_out   = (st == S_ADDR) ? addr_word : (st == S_DATA) ? data_word : 32'd0;
  assign cbe_n    = (st == S_ADDR) ? 4'b1011 : (st == S_DATA) ? ~be_word : 4'hF;

  a_r1_zero_key_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && irdy_n && !host_rdy && host_req && cfg_key == '0) |=> frame_n);

  a_r3_onehot_idsel: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> (ad_oe && $countones(ad_out[31:17]) == 1 && ad_out[1:0] == 2'b00));

  a_r4_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (frame_n && !irdy_n));

  a_r4_cfg_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> cbe_n == 4'b1011);

  a_r6_irdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && trdy_n) |=> (!irdy_n && ad_oe));

  a_r7_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |=> !host_rdy);

  a_r7_rdy_after_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |-> ($past(!irdy_n && !trdy_n) && !ad_oe && irdy_n));

endmodule

// File: tb/test_pci_cfg_wr_seq.sv
`timescale 1ns/1ps
module test_pci_cfg_wr_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  cfg_key = 0;
  logic        host_req = 0;
  logic [15:2] host_addr = 0;
  logic [7:0]  host_be = 0;
  logic [63:0] host_data = 0;
  logic        host_rdy, frame_n, irdy_n, ad_oe;
  logic        trdy_n = 1;
  logic [3:0]  cbe_n;
  logic [31:0] ad_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pci_cfg_wr_seq #(.KEY_W(8)) i_pci_cfg_wr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_key(cfg_key), .host_req(host_req),
    .host_addr(host_addr), .host_be(host_be), .host_data(host_data),
    .host_rdy(host_rdy), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe));

  // {device, offset, byte enables, wait states, expected address word}
  localparam logic [54:0] VEC [15] = '{
    {4'd1,  8'h07, 8'h3C, 3'd0, 32'h0002_0004},
    {4'd2,  8'h10, 8'hA5, 3'd1, 32'h0004_0010},
    {4'd3,  8'h3C, 8'h0F, 3'd2, 32'h0008_003C},
    {4'd4,  8'h41, 8'hF1, 3'd3, 32'h0010_0040},
    {4'd5,  8'h84, 8'h96, 3'd4, 32'h0020_0084},
    {4'd6,  8'hFF, 8'h81, 3'd0, 32'h0040_00FC},
    {4'd7,  8'h00, 8'h7E, 3'd1, 32'h0080_0000},
    {4'd8,  8'h22, 8'h12, 3'd2, 32'h0100_0020},
    {4'd9,  8'h9B, 8'hC3, 3'd3, 32'h0200_0098},
    {4'd10, 8'hC6, 8'h5A, 3'd4, 32'h0400_00C4},
    {4'd11, 8'h5D, 8'hE7, 3'd0, 32'h0800_005C},
    {4'd12, 8'hE8, 8'h08, 3'd1, 32'h1000_00E8},
    {4'd13, 8'h0F, 8'h40, 3'd2, 32'h2000_000C},
    {4'd14, 8'h70, 8'hFF, 3'd3, 32'h4000_0070},
    {4'd15, 8'hAA, 8'h21, 3'd4, 32'h8000_00A8}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk(req, {frame_n, irdy_n, host_rdy, ad_oe}, 4'b1100);
    end
  endtask

  task automatic do_write(input logic [3:0] n, input logic [7:0] off, input logic [7:0] be,
                          input int wt, input logic [31:0] exp_ad, input bit busy_req);
    logic [63:0] d;
    logic [31:0] exp_d;
    logic [3:0]  exp_be;
    d = {28'hA000_000, n, 28'h5000_000, n};
    exp_d  = off[2] ? d[63:32] : d[31:0];
    exp_be = ~(off[2] ? be[7:4] : be[3:0]);
    host_addr = {4'hC, n, off[7:2]};
    host_be = be; host_data = d; host_req = 1;
    @(negedge clk);
    host_req = 0; host_data = '0; host_be = '0;
    chk("R3 address word", ad_out, exp_ad);
    chk("R3 drive enable", ad_oe, 1'b1);
    chk("R4 frame/cmd", {frame_n, irdy_n, cbe_n}, {2'b01, 4'b1011});
    @(negedge clk);
    chk("R4 frame one clock", frame_n, 1'b1);
    chk("R5 data dword", ad_out, exp_d);
    chk("R5 data byte enables", cbe_n, exp_be);
    chk("R6 irdy low", {irdy_n, ad_oe}, 2'b01);
    if (busy_req) begin
      host_addr = {4'hC, 4'd3, 6'd1}; host_req = 1;
    end
    for (int w = 0; w < wt; w++) begin
      @(negedge clk);
      host_req = 0;
      chk("R6 wait state hold", {irdy_n, ad_oe, host_rdy, ad_out}, {3'b010, exp_d});
    end
    trdy_n = 0;
    @(negedge clk);
    trdy_n = 1; host_req = 0;
    chk("R7 completion", {host_rdy, irdy_n, ad_oe}, 3'b110);
    @(negedge clk);
    chk("R7 ready one clock", {host_rdy, frame_n, irdy_n, ad_oe}, 4'b0110);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R9 reset outputs", {frame_n, irdy_n, cbe_n, ad_oe, host_rdy, ad_out},
        {2'b11, 4'hF, 2'b00, 32'd0});
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle after reset", {frame_n, irdy_n, cbe_n, ad_oe, host_rdy}, {2'b11, 4'hF, 2'b00});

    // R1: zero key blocks a valid window access
    host_addr = {4'hC, 4'd5, 6'h04}; host_req = 1;
    @(negedge clk); host_req = 0;
    chk("R1 zero key no frame", {frame_n, ad_oe}, 2'b10);
    quiet(3, "R1 zero key quiet");

    cfg_key = 8'h01;
    for (int i = 0; i < 15; i++)
      do_write(VEC[i][54:51], VEC[i][50:43], VEC[i][42:35], int'(VEC[i][34:32]), VEC[i][31:0], 1'b0);

    // R2: device 0 and a non-window nibble are ignored
    host_addr = {4'hC, 4'd0, 6'h01}; host_req = 1;
    @(negedge clk); host_req = 0;
    chk("R2 device zero ignored", {frame_n, ad_oe}, 2'b10);
    quiet(2, "R2 device zero quiet");
    host_addr = {4'hD, 4'd3, 6'h01}; host_req = 1;
    @(negedge clk); host_req = 0;
    chk("R2 outside window ignored", {frame_n, ad_oe}, 2'b10);
    quiet(2, "R2 outside window quiet");

    // R8: request during a busy cycle is dropped
    cfg_key = 8'h80;
    do_write(4'd9, 8'h14, 8'h33, 2, 32'h0200_0014, 1'b1);
    quiet(4, "R8 busy request dropped");

    // R1: key cleared again after use
    cfg_key = 8'h00;
    host_addr = {4'hC, 4'd15, 6'h3F}; host_req = 1;
    @(negedge clk); host_req = 0;
    quiet(3, "R1 key cleared quiet");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule